// File: doc/BRIEF.md
# SPI Flash User-Mode Access Controller

This block gives a host direct, byte-level control of up to a configured number of serial flash devices. Software programs a small register set: a configuration word with one write-enable bit per chip select, and one control word per chip select. Each control word carries an access mode, a command byte and a stop bit. The stop bit drives that device's active-low select line directly, so software frames every flash command itself by clearing and setting the bit around its accesses.

Data moves through a separate flash-window port. When the targeted chip select is in user mode, a window access of one to four bytes becomes the same number of SPI byte exchanges, least significant byte first. A write shifts out the host data. A read shifts out zeros and packs the returned bytes into a little-endian word. Writes are dropped when the chip select lacks its write enable or is not in user mode. Reads outside user mode return all ones and cause no bus activity.

The SPI engine uses clock mode 0 and sends each byte most significant bit first. The serial clock is the system clock divided by a fixed ratio.

Top module: `sfu_top`

## Requirements
- R1: After reset the configuration register reads 0x00000000, the status register at offset 0x08 reads 0x00000800 (done flag, bit 11), every control register reads 0x00000004, all chip-select outputs are high, SCLK is low and the window port is ready.
- R2: The control register for chip select i sits at byte offset 0x10 + 4*i and stores all 32 bits. Bits 1:0 are the mode (0 normal, 1 fast, 2 program, 3 user) and bits 23:16 are the command byte. Bit 2 is the stop bit, and spi_cs_n[i] takes its value on the clock edge that writes the register.
- R3: The configuration register at offset 0x00 stores all 32 bits; bit 16+i is the write enable of chip select i.
- R4: The status register is read-only: writes leave it at 0x00000800. Any other offset, including offsets whose low two bits are non-zero, reads 0 and ignores writes.
- R5: A window write to a chip select in user mode with its write enable set sends win_nbytes+1 bytes of win_wdata, lowest byte first.
- R6: A window write to a chip select whose write enable is clear, or whose mode is not user, produces no SCLK activity and completes with win_done.
- R7: A window read to a chip select in user mode sends 0x00 for each of the win_nbytes+1 bytes, whatever its write enable. Byte k received lands in win_rdata bits 8k+7:8k and the unused upper bytes read 0.
- R8: A window read to a chip select not in user mode returns 0xFFFFFFFF and causes no SCLK activity.
- R9: SCLK idles low. Each high half lasts CLK_DIV system clocks, MOSI is stable while SCLK is high, and MISO is sampled at the rising SCLK edge.
- R10: A request is taken when win_req and win_ready are both high. win_ready stays low until the last byte has been exchanged. win_done is a single-cycle pulse, issued while win_ready is high, and win_rdata is valid during it.
- R11: Only min(NUM_CS, MAX_CS) chip selects exist. Control offsets beyond them read 0 and ignore writes, window reads to them return 0xFFFFFFFF, window writes to them are dropped, and surplus select lines stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| win_req | input | 1 | Window access request |
| win_we | input | 1 | 1 = window write, 0 = window read |
| win_cs | input | CSEL_W | Target chip select index |
| win_nbytes | input | 2 | Access length minus one (0..3) |
| win_wdata | input | 32 | Window write data, little-endian |
| win_ready | output | 1 | Window port idle and able to accept a request |
| win_done | output | 1 | One-cycle completion pulse |
| win_rdata | output | 32 | Window read result |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | NUM_CS | Active-low chip selects |

## Verification
The assertions check on every cycle that a control-register write moves the first select line to the written stop bit on the next cycle, that the status offset always reads its fixed value, that MOSI holds while SCLK is high, that SCLK is idle whenever the window port is ready, and that the completion pulse lasts one cycle. Only the bench scenarios show the data path. A flash model behind the serial pins shows the byte order on the wire, the gating of writes by write enable and mode, the packing of read data, the all-ones result outside user mode, and the handling of chip selects beyond the configured count.

// File: rtl/sfu_pkg.sv
package sfu_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_FAST   = 2'd1,
    MODE_PROG   = 2'd2,
    MODE_USER   = 2'd3
  } sfu_mode_e;

  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_RUN  = 1'b1
  } sfu_seq_e;

  localparam logic [7:0]  OFS_CFG    = 8'h00;
  localparam logic [7:0]  OFS_STAT   = 8'h08;
  localparam int          OFS_CTRL0  = 16;
  localparam int          WEN_LSB    = 16;
  localparam int          STOP_BIT   = 2;
  localparam logic [31:0] STAT_VALUE = 32'h0000_0800;
  localparam logic [31:0] CTRL_RST   = 32'h0000_0004;
endpackage

// File: rtl/sfu_rst_sync.sv
module sfu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/sfu_regfile.sv
module sfu_regfile
  import sfu_pkg::*;
#(
  parameter int CS_N = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [7:0]      addr,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata,
  output logic [CS_N-1:0] cs_n,
  output logic [CS_N-1:0] cs_wen,
  output logic [CS_N-1:0] cs_user
);
  logic [31:0] cfg_q;
  logic        cfg_en;
  logic [31:0] ctrl_q [CS_N];
  logic [CS_N-1:0] ctrl_en;
  logic [CS_N-1:0] ctrl_hit;

  assign cfg_en = wr && (addr == OFS_CFG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_en) cfg_q <= wdata;
  end

  for (genvar i = 0; i < CS_N; i++) begin : g_cs
    localparam logic [7:0] MY_OFS = 8'(OFS_CTRL0 + 4 * i);

    assign ctrl_hit[i] = (addr == MY_OFS);
    assign ctrl_en[i]  = wr && ctrl_hit[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ctrl_q[i] <= CTRL_RST;
      else if (ctrl_en[i]) ctrl_q[i] <= wdata;
    end

    assign cs_n[i]    = ctrl_q[i][STOP_BIT];
    assign cs_user[i] = (ctrl_q[i][1:0] == MODE_USER);
    assign cs_wen[i]  = cfg_q[WEN_LSB + i];
  end

  always_comb begin
    rdata = '0;
    if (addr == OFS_CFG)  rdata = cfg_q;
    if (addr == OFS_STAT) rdata = STAT_VALUE;
    for (int k = 0; k < CS_N; k++) begin
      if (ctrl_hit[k]) rdata = ctrl_q[k];
    end
  end
endmodule

// File: rtl/sfu_byte_shift.sv
module sfu_byte_shift #(
  parameter int HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx,
  output logic       done,
  output logic [7:0] rx,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso
);
  localparam int DW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(HALF - 1);

  logic          act_q, act_d;
  logic          hi_q, hi_d;
  logic [DW-1:0] div_q, div_d;
  logic [2:0]    bit_q, bit_d;
  logic [7:0]    tx_q, tx_d;
  logic [7:0]    rx_q, rx_d;
  logic          done_q, done_d;
  logic          tick;

  assign tick = act_q && (div_q == DIV_LAST);

  always_comb begin
    act_d  = act_q;
    hi_d   = hi_q;
    div_d  = div_q;
    bit_d  = bit_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    done_d = 1'b0;
    if (!act_q) begin
      if (start) begin
        act_d = 1'b1;
        hi_d  = 1'b0;
        div_d = '0;
        bit_d = '0;
        tx_d  = tx;
      end
    end else begin
      div_d = tick ? '0 : div_q + 1'b1;
      if (tick) begin
        if (!hi_q) begin
          hi_d = 1'b1;
          rx_d = {rx_q[6:0], miso};
        end else begin
          hi_d = 1'b0;
          if (bit_q == 3'd7) begin
            act_d  = 1'b0;
            done_d = 1'b1;
          end else begin
            bit_d = bit_q + 1'b1;
            tx_d  = {tx_q[6:0], 1'b0};
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      hi_q   <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      done_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      hi_q   <= hi_d;
      div_q  <= div_d;
      bit_q  <= bit_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      done_q <= done_d;
    end
  end

  assign sclk = hi_q;
  assign mosi = act_q & tx_q[7];
  assign done = done_q;
  assign rx   = rx_q;
endmodule

// File: rtl/sfu_win_seq.sv
module sfu_win_seq
  import sfu_pkg::*;
#(
  parameter int CS_N   = 5,
  parameter int CSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [CSEL_W-1:0] csel,
  input  logic [1:0]        nbytes,
  input  logic [31:0]       wdata,
  input  logic [CS_N-1:0]   cs_wen,
  input  logic [CS_N-1:0]   cs_user,
  output logic              ready,
  output logic              done,
  output logic [31:0]       rdata,
  output logic              bstart,
  output logic [7:0]        btx,
  input  logic              bdone,
  input  logic [7:0]        brx
);
  sfu_seq_e    st_q, st_d;
  logic [1:0]  idx_q, idx_d;
  logic [1:0]  last_q, last_d;
  logic        wr_q, wr_d;
  logic [31:0] wbuf_q, wbuf_d;
  logic [31:0] rbuf_q, rbuf_d;
  logic        done_q, done_d;
  logic        start_q, start_d;
  logic        sel_user, sel_wen, pass;

  always_comb begin
    sel_user = 1'b0;
    sel_wen  = 1'b0;
    for (int k = 0; k < CS_N; k++) begin
      if (csel == CSEL_W'(k)) begin
        sel_user = cs_user[k];
        sel_wen  = cs_wen[k];
      end
    end
    pass = we ? (sel_user && sel_wen) : sel_user;
  end

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    last_d  = last_q;
    wr_d    = wr_q;
    wbuf_d  = wbuf_q;
    rbuf_d  = rbuf_q;
    done_d  = 1'b0;
    start_d = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (req) begin
          if (pass) begin
            st_d    = SQ_RUN;
            idx_d   = '0;
            last_d  = nbytes;
            wr_d    = we;
            wbuf_d  = wdata;
            rbuf_d  = '0;
            start_d = 1'b1;
          end else begin
            done_d = 1'b1;
            rbuf_d = we ? '0 : '1;
          end
        end
      end
      SQ_RUN: begin
        if (bdone) begin
          rbuf_d[{idx_q, 3'b000} +: 8] = brx;
          if (idx_q == last_q) begin
            st_d   = SQ_IDLE;
            done_d = 1'b1;
          end else begin
            idx_d   = idx_q + 1'b1;
            start_d = 1'b1;
          end
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      idx_q   <= '0;
      last_q  <= '0;
      wr_q    <= 1'b0;
      wbuf_q  <= '0;
      rbuf_q  <= '0;
      done_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      last_q  <= last_d;
      wr_q    <= wr_d;
      wbuf_q  <= wbuf_d;
      rbuf_q  <= rbuf_d;
      done_q  <= done_d;
      start_q <= start_d;
    end
  end

  assign ready  = (st_q == SQ_IDLE);
  assign done   = done_q;
  assign rdata  = rbuf_q;
  assign bstart = start_q;
  assign btx    = wr_q ? wbuf_q[{idx_q, 3'b000} +: 8] : 8'h00;
endmodule

// File: rtl/sfu_top.sv
module sfu_top #(
  parameter int NUM_CS  = 5,
  parameter int MAX_CS  = 5,
  parameter int CSEL_W  = 3,
  parameter int CLK_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              win_req,
  input  logic              win_we,
  input  logic [CSEL_W-1:0] win_cs,
  input  logic [1:0]        win_nbytes,
  input  logic [31:0]       win_wdata,
  output logic              win_ready,
  output logic              win_done,
  output logic [31:0]       win_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_cs_n
);
  localparam int CS_N = (NUM_CS > MAX_CS) ? MAX_CS : NUM_CS;

  logic            rs_n;
  logic [CS_N-1:0] cs_n_w, cs_wen_w, cs_user_w;
  logic            bstart, bdone;
  logic [7:0]      btx, brx;

  sfu_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rs_n)
  );

  sfu_regfile #(.CS_N(CS_N)) u_regs (
    .clk     (clk),
    .rst_n   (rs_n),
    .wr      (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .cs_n    (cs_n_w),
    .cs_wen  (cs_wen_w),
    .cs_user (cs_user_w)
  );

  sfu_win_seq #(.CS_N(CS_N), .CSEL_W(CSEL_W)) u_seq (
    .clk     (clk),
    .rst_n   (rs_n),
    .req     (win_req),
    .we      (win_we),
    .csel    (win_cs),
    .nbytes  (win_nbytes),
    .wdata   (win_wdata),
    .cs_wen  (cs_wen_w),
    .cs_user (cs_user_w),
    .ready   (win_ready),
    .done    (win_done),
    .rdata   (win_rdata),
    .bstart  (bstart),
    .btx     (btx),
    .bdone   (bdone),
    .brx     (brx)
  );

  sfu_byte_shift #(.HALF(CLK_DIV)) u_shift (
    .clk   (clk),
    .rst_n (rs_n),
    .start (bstart),
    .tx    (btx),
    .done  (bdone),
    .rx    (brx),
    .sclk  (spi_sclk),
    .mosi  (spi_mosi),
    .miso  (spi_miso)
  );

  for (genvar i = 0; i < NUM_CS; i++) begin : g_csout
    if (i < CS_N) begin : g_live
      assign spi_cs_n[i] = cs_n_w[i];
    end else begin : g_idle
      assign spi_cs_n[i] = 1'b1;
    end
  end
endmodule

// File: rtl/sfu_chk.sv
module sfu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [7:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        win_ready,
  input logic        win_done,
  input logic        spi_sclk,
  input logic        spi_mosi,
  input logic        spi_cs0_n
);
  // R2: select line 0 follows the stop bit written to its control word
  a_r2_cs_follows_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 8'h10) |=> (spi_cs0_n == $past(reg_wdata[2])));

  // R4: status offset always reads its fixed value
  a_r4_status_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 8'h08) |-> (reg_rdata == 32'h0000_0800));

  // R9: MOSI holds through each high half of SCLK
  a_r9_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

  // R10: no serial clock while the window port is idle
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    win_ready |-> !spi_sclk);

  // R10: completion is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |=> !win_done);

  // R10: completion is signalled with the port ready again
  a_r10_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |-> win_ready);
endmodule

bind sfu_top sfu_chk u_chk (
  .clk       (clk),
  .rst_n     (rs_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .win_ready (win_ready),
  .win_done  (win_done),
  .spi_sclk  (spi_sclk),
  .spi_mosi  (spi_mosi),
  .spi_cs0_n (spi_cs_n[0])
);

// File: tb/sim_sfu_top.sv
`timescale 1ns/1ps
module sim_sfu_top;
  localparam int NCS = 3;
  localparam int DIV = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        win_req, win_we;
  logic [2:0]  win_cs;
  logic [1:0]  win_nbytes;
  logic [31:0] win_wdata;
  logic        win_ready, win_done;
  logic [31:0] win_rdata;
  logic        spi_sclk, spi_mosi, spi_miso;
  logic [NCS-1:0] spi_cs_n;

  int vecs = 0;
  int miss = 0;

  always #2.5 clk = ~clk;

  sfu_top #(.NUM_CS(NCS), .MAX_CS(5), .CSEL_W(3), .CLK_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .win_req(win_req),
    .win_we(win_we), .win_cs(win_cs), .win_nbytes(win_nbytes),
    .win_wdata(win_wdata), .win_ready(win_ready), .win_done(win_done),
    .win_rdata(win_rdata), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] resp_byte(input int k);
    return 8'(8'h5A + k * 8'h1D);
  endfunction

  // flash model and scoreboard monitor
  logic [7:0] exp_q[$];
  string      tag_q[$];
  int         bc = 0;
  int         gcount = 0;
  logic [7:0] cap = 8'h00;
  logic [7:0] cur_resp;
  realtime    t_rise = 0;

  assign cur_resp = resp_byte(gcount);
  assign spi_miso = cur_resp[3'(7 - bc)];

  always @(posedge spi_sclk) begin
    t_rise = $realtime;
    cap = {cap[6:0], spi_mosi};
    if (bc == 7) begin
      if (exp_q.size() == 0) begin
        check("R6", "unexpected SPI byte", {24'h0, cap}, 32'hxxxx_xxxx);
      end else begin
        check(tag_q.pop_front(), "MOSI byte", {24'h0, cap}, {24'h0, exp_q.pop_front()});
      end
    end
  end

  always @(negedge spi_sclk) begin
    check("R9", "SCLK high time ns", 32'($rtoi($realtime - t_rise)), 32'(DIV * 5));
    if (bc == 7) begin
      bc = 0;
      gcount++;
    end else begin
      bc++;
    end
  end

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_check(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(req, $sformatf("reg 0x%02h", a), reg_rdata, exp);
  endtask

  // driver: pushes expected bytes, issues the access, checks the result
  task automatic win_access(input string req, input logic we, input logic [2:0] cs,
                            input logic [1:0] nb, input logic [31:0] wd,
                            input bit moves, input bit chk_rd, input logic [31:0] exp_rd);
    int guard;
    logic [31:0] rd_exp;
    rd_exp = exp_rd;
    if (moves) begin
      if (!we) rd_exp = '0;
      for (int k = 0; k <= int'(nb); k++) begin
        exp_q.push_back(we ? wd[8*k +: 8] : 8'h00);
        tag_q.push_back(req);
        if (!we) rd_exp[8*k +: 8] = resp_byte(gcount + k);
      end
    end
    @(negedge clk);
    win_req = 1'b1; win_we = we; win_cs = cs; win_nbytes = nb; win_wdata = wd;
    @(negedge clk);
    win_req = 1'b0;
    if (moves) check("R10", "ready low during transfer", {31'h0, win_ready}, 32'h0);
    guard = 0;
    while (!win_done && guard < 4000) begin
      @(negedge clk);
      guard++;
    end
    check("R10", "completion seen", {31'h0, win_done}, 32'h1);
    if (chk_rd) check(req, "window read data", win_rdata, rd_exp);
    @(negedge clk);
    check("R10", "done is one cycle", {31'h0, win_done}, 32'h0);
    check(req, "bytes outstanding", 32'(exp_q.size()), 32'h0);
    check("R10", "ready after done", {31'h0, win_ready}, 32'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miss++;
    $display("FAIL R10 watchdog: got hang expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    win_req = 1'b0; win_we = 1'b0; win_cs = '0; win_nbytes = '0; win_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    reg_check("R1", 8'h00, 32'h0);
    reg_check("R1", 8'h08, 32'h0000_0800);
    reg_check("R1", 8'h10, 32'h4);
    reg_check("R1", 8'h18, 32'h4);
    check("R1", "cs_n", {29'h0, spi_cs_n}, 32'h7);
    check("R1", "sclk idle", {31'h0, spi_sclk}, 32'h0);
    check("R1", "ready", {31'h0, win_ready}, 32'h1);

    // R2 control words
    reg_write(8'h10, 32'h00AB_0003);
    check("R2", "cs0 asserted", {29'h0, spi_cs_n}, 32'h6);
    reg_check("R2", 8'h10, 32'h00AB_0003);
    reg_write(8'h14, 32'h0012_0007);
    check("R2", "cs1 stop set", {29'h0, spi_cs_n}, 32'h6);
    reg_write(8'h14, 32'h0000_0003);
    check("R2", "cs1 asserted", {29'h0, spi_cs_n}, 32'h4);

    // R3 configuration: write enable for cs0 only
    reg_write(8'h00, 32'h8001_0000);
    reg_check("R3", 8'h00, 32'h8001_0000);

    // R4 read-only status and unimplemented offsets
    reg_write(8'h08, 32'h0);
    reg_check("R4", 8'h08, 32'h0000_0800);
    reg_write(8'h04, 32'hDEAD_BEEF);
    reg_check("R4", 8'h04, 32'h0);
    reg_write(8'h11, 32'h1234_5678);
    reg_check("R4", 8'h11, 32'h0);
    reg_check("R4", 8'h10, 32'h00AB_0003);
    reg_check("R4", 8'hFC, 32'h0);

    // R5 user-mode writes, lowest byte first
    win_access("R5", 1'b1, 3'd0, 2'd3, 32'h1122_3344, 1'b1, 1'b0, 32'h0);
    win_access("R5", 1'b1, 3'd0, 2'd1, 32'h0000_BEEF, 1'b1, 1'b0, 32'h0);
    win_access("R5", 1'b1, 3'd0, 2'd0, 32'hFFFF_FF81, 1'b1, 1'b0, 32'h0);

    // R6 dropped writes: no write enable, then wrong mode
    win_access("R6", 1'b1, 3'd1, 2'd3, 32'hCAFE_F00D, 1'b0, 1'b0, 32'h0);
    check("R6", "sclk idle after drop", {31'h0, spi_sclk}, 32'h0);
    reg_write(8'h10, 32'h00AB_0002);
    win_access("R6", 1'b1, 3'd0, 2'd3, 32'hCAFE_F00D, 1'b0, 1'b0, 32'h0);
    reg_write(8'h10, 32'h00AB_0003);

    // R7 user-mode reads, with and without write enable
    win_access("R7", 1'b0, 3'd0, 2'd2, 32'h0, 1'b1, 1'b1, 32'h0);
    win_access("R7", 1'b0, 3'd1, 2'd3, 32'h0, 1'b1, 1'b1, 32'h0);
    win_access("R7", 1'b0, 3'd0, 2'd0, 32'h0, 1'b1, 1'b1, 32'h0);

    // R8 read outside user mode
    reg_write(8'h10, 32'h00AB_0000);
    win_access("R8", 1'b0, 3'd0, 2'd3, 32'h0, 1'b0, 1'b1, 32'hFFFF_FFFF);
    reg_write(8'h10, 32'h00AB_0001);
    win_access("R8", 1'b0, 3'd0, 2'd1, 32'h0, 1'b0, 1'b1, 32'hFFFF_FFFF);

    // R11 chip selects beyond the configured count
    reg_write(8'h1C, 32'h0000_0003);
    reg_check("R11", 8'h1C, 32'h0);
    reg_write(8'h00, 32'h000F_0000);
    win_access("R11", 1'b0, 3'd3, 2'd3, 32'h0, 1'b0, 1'b1, 32'hFFFF_FFFF);
    win_access("R11", 1'b1, 3'd4, 2'd3, 32'h5555_AAAA, 1'b0, 1'b0, 32'h0);

    // R2 stop bit released again deselects
    reg_write(8'h10, 32'h0000_0004);
    reg_write(8'h14, 32'h0000_0004);
    check("R2", "all deselected", {29'h0, spi_cs_n}, 32'h7);

    repeat (4) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule